// File: doc/BRIEF.md
# LED and Keypad Matrix Scanner

This block time-multiplexes a single set of column lines between an LED matrix and a matrix of push-to-make switches. A prescaler divides the clock so that each column stays active for a fixed number of cycles. During that time exactly one column line is high, and the row outputs carry the LED pattern for that column. The pattern comes from a small pixel store that is indexed by column.

The same active column also powers one column of the switch matrix. The switch row lines pass through a short synchronizer and are sampled late in the column period, once the drive has settled. Each sample is compared with the last value stored for that column. When they differ, the stored value is updated and a one-cycle change strobe reports the column and its new row bits.

A host port can rewrite the pixel store while scanning continues. The store has a single port. When the scanner fetch and a host write fall in the same cycle, the fetch goes first and the write is held for one cycle. Each column's pattern is latched whole at the column boundary, so a displayed column never shows a half-updated word.

Top module: `led_key_scanner`

## Requirements
- R1: While reset is high and until the first column boundary after it, `col_drive`, `row_led` and `key_state` are all zero and `key_change` is low.
- R2: `col_drive` never has more than one bit set. After the first boundary it has exactly one bit set, and the active column steps 0, 1, …, COLS-1 and then back to 0.
- R3: Each column stays active for exactly PRESCALE clocks, so a frame lasts COLS×PRESCALE clocks. With the default parameters at 100 MHz, a frame is shorter than 20 ms, giving a frame rate above 50 Hz.
- R4: While column c is active, `row_led` equals the pixel word at address c, with bit r driving row r. `row_led` and `col_drive` change only at column boundaries.
- R5: A host write (`host_we` high for one cycle with `host_addr` and `host_data`) that does not collide with a scanner fetch is stored at once. It is shown the next time that column is displayed.
- R6: A host write made in the cycle of the scanner fetch for the same column is held for one cycle. That column's display then shows the old word, and the new word appears one frame later. A second write in the following cycle is stored after the held one, so the later write wins.
- R7: A high level on `row_sense[r]` while column c is active means the switch at column c, row r is pressed. Its state is held in `key_state[c*ROWS + r]`. Rows are sampled SAMPLE_AT clocks into the column period, after SYNC synchronizer stages.
- R8: When a column's sampled rows differ from its stored value, `key_change` pulses high for one cycle. During that cycle `key_change_col` gives the column and `key_change_rows` gives the new row bits. A sample equal to the stored value raises no pulse.
- R9: `key_state` keeps the last sampled row value of every column until that column is sampled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_we | input | 1 | Host pixel write enable |
| host_addr | input | $clog2(COLS) | Column address of the host write |
| host_data | input | ROWS | LED row pattern to store |
| row_sense | input | ROWS | Switch row lines, pressed = high |
| col_drive | output | COLS | Column drive, one-hot while scanning |
| row_led | output | ROWS | LED row pattern for the active column |
| key_state | output | COLS*ROWS | Stored switch state, bit c*ROWS+r |
| key_change | output | 1 | One-cycle strobe on a changed column sample |
| key_change_col | output | $clog2(COLS) | Column of the reported change |
| key_change_rows | output | ROWS | New row bits of the reported change |

## Verification
The column lines and the LED rows move together on the boundary edge. That edge comes one clock after the fetch, which is taken PRESCALE-2 clocks into the previous column. A key change is reported in the cycle after the sample point, which lies SAMPLE_AT clocks into the column. The bench locks onto the negative edge that follows a column change and counts negative edges from there. This lets a collision write be placed exactly on the fetch cycle and lets the period be measured in whole clocks. Expected key events sit in a queue and are popped only when the strobe rises. Pixel expectations are updated only one edge after the target column is shown, so no expectation moves between a fetch and the display it feeds.

// File: rtl/scan_pkg.sv
package scan_pkg;

  localparam int unsigned MIN_FRAME_HZ = 50;

  typedef enum logic [1:0] {
    PORT_IDLE,
    PORT_SCAN,
    PORT_HOST,
    PORT_HELD
  } port_use_e;

  function automatic longint unsigned frame_clocks(int unsigned cols, int unsigned prescale);
    return longint'(cols) * longint'(prescale);
  endfunction

endpackage

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int COLS      = 8,
  parameter int PRESCALE  = 16,
  parameter int SAMPLE_AT = 13
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic [$clog2(COLS)-1:0] col_idx,
  output logic [$clog2(COLS)-1:0] next_col,
  output logic                    fetch,
  output logic                    boundary,
  output logic                    sample,
  output logic                    live
);
  localparam int CW = $clog2(COLS);
  localparam int PW = $clog2(PRESCALE);

  logic [PW-1:0] cnt;

  always_comb begin
    next_col = (col_idx == CW'(COLS - 1)) ? '0 : col_idx + CW'(1);
    fetch    = (cnt == PW'(PRESCALE - 2));
    boundary = (cnt == PW'(PRESCALE - 1));
    sample   = live && (cnt == PW'(SAMPLE_AT));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      col_idx <= CW'(COLS - 1);
      live    <= 1'b0;
    end else if (boundary) begin
      cnt     <= '0;
      col_idx <= next_col;
      live    <= 1'b1;
    end else begin
      cnt <= cnt + PW'(1);
    end
  end

  // R3: the fetch and the boundary fall in neighbouring cycles
  p_fetch_then_edge_r3: assert property (@(posedge clk) disable iff (rst)
    fetch |=> boundary);

endmodule

// File: rtl/pixel_store.sv
module pixel_store #(
  parameter int COLS = 8,
  parameter int ROWS = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    scan_rd,
  input  logic [$clog2(COLS)-1:0] scan_addr,
  input  logic                    host_we,
  input  logic [$clog2(COLS)-1:0] host_addr,
  input  logic [ROWS-1:0]         host_data,
  output logic [ROWS-1:0]         rd_data
);
  import scan_pkg::*;
  localparam int AW = $clog2(COLS);

  logic [ROWS-1:0] mem [COLS];

  logic            held_v;
  logic [AW-1:0]   held_a;
  logic [ROWS-1:0] held_d;

  port_use_e       use_now;
  logic            wr_en;
  logic [AW-1:0]   wr_addr;
  logic [ROWS-1:0] wr_data;

  always_comb begin
    if (scan_rd)      use_now = PORT_SCAN;
    else if (held_v)  use_now = PORT_HELD;
    else if (host_we) use_now = PORT_HOST;
    else              use_now = PORT_IDLE;
    wr_en   = (use_now == PORT_HELD) || (use_now == PORT_HOST);
    wr_addr = (use_now == PORT_HELD) ? held_a : host_addr;
    wr_data = (use_now == PORT_HELD) ? held_d : host_data;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (scan_rd) rd_data <= mem[scan_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held_v <= 1'b0;
    end else if (use_now == PORT_SCAN || use_now == PORT_HELD) begin
      held_v <= host_we;
    end else begin
      held_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (host_we) begin
      held_a <= host_addr;
      held_d <= host_data;
    end
  end

  // R6: a write that meets a fetch is kept for the next cycle
  p_defer_write_r6: assert property (@(posedge clk) disable iff (rst)
    (scan_rd && host_we) |=> held_v);

  // R6: a held write never meets a second fetch
  p_held_drains_r6: assert property (@(posedge clk) disable iff (rst)
    held_v |-> !scan_rd);

  // R5: the store is never written in a fetch cycle
  p_no_write_on_fetch_r5: assert property (@(posedge clk) disable iff (rst)
    scan_rd |-> !wr_en);

endmodule

// File: rtl/key_capture.sv
module key_capture #(
  parameter int COLS = 8,
  parameter int ROWS = 8,
  parameter int SYNC = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ROWS-1:0]         row_sense,
  input  logic                    sample,
  input  logic [$clog2(COLS)-1:0] col_idx,
  output logic [COLS*ROWS-1:0]    key_state,
  output logic                    key_change,
  output logic [$clog2(COLS)-1:0] key_change_col,
  output logic [ROWS-1:0]         key_change_rows
);
  logic [ROWS-1:0] sync_q [SYNC];

  for (genvar s = 0; s < SYNC; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[s] <= '0;
        else     sync_q[s] <= row_sense;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sync_q[s] <= '0;
        else     sync_q[s] <= sync_q[s-1];
      end
    end
  end

  logic [ROWS-1:0] rows_now;
  logic [ROWS-1:0] rows_kept;
  int              base;

  always_comb begin
    rows_now  = sync_q[SYNC-1];
    base      = int'(col_idx) * ROWS;
    rows_kept = key_state[base +: ROWS];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      key_state       <= '0;
      key_change      <= 1'b0;
      key_change_col  <= '0;
      key_change_rows <= '0;
    end else begin
      key_change <= 1'b0;
      if (sample) begin
        key_state[base +: ROWS] <= rows_now;
        if (rows_now != rows_kept) begin
          key_change      <= 1'b1;
          key_change_col  <= col_idx;
          key_change_rows <= rows_now;
        end
      end
    end
  end

  // R8: the strobe lasts a single cycle
  p_change_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    key_change |=> !key_change);

  // R9: the reported rows are what the state now holds for that column
  p_change_stored_r9: assert property (@(posedge clk) disable iff (rst)
    key_change |-> (key_state[int'(key_change_col) * ROWS +: ROWS] == key_change_rows));

endmodule

// File: rtl/led_key_scanner.sv
module led_key_scanner #(
  parameter int          COLS      = 8,
  parameter int          ROWS      = 8,
  parameter int          PRESCALE  = 16,
  parameter int          SAMPLE_AT = 13,
  parameter int          SYNC      = 2,
  parameter int unsigned CLK_HZ    = 100_000_000
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    host_we,
  input  logic [$clog2(COLS)-1:0] host_addr,
  input  logic [ROWS-1:0]         host_data,
  input  logic [ROWS-1:0]         row_sense,
  output logic [COLS-1:0]         col_drive,
  output logic [ROWS-1:0]         row_led,
  output logic [COLS*ROWS-1:0]    key_state,
  output logic                    key_change,
  output logic [$clog2(COLS)-1:0] key_change_col,
  output logic [ROWS-1:0]         key_change_rows
);
  import scan_pkg::*;
  localparam int CW = $clog2(COLS);

  logic [CW-1:0]   col_idx;
  logic [CW-1:0]   next_col;
  logic            fetch;
  logic            boundary;
  logic            sample;
  logic            live;
  logic [ROWS-1:0] rd_data;

  scan_timer #(.COLS(COLS), .PRESCALE(PRESCALE), .SAMPLE_AT(SAMPLE_AT)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .col_idx  (col_idx),
    .next_col (next_col),
    .fetch    (fetch),
    .boundary (boundary),
    .sample   (sample),
    .live     (live)
  );

  pixel_store #(.COLS(COLS), .ROWS(ROWS)) u_pixels (
    .clk       (clk),
    .rst       (rst),
    .scan_rd   (fetch),
    .scan_addr (next_col),
    .host_we   (host_we),
    .host_addr (host_addr),
    .host_data (host_data),
    .rd_data   (rd_data)
  );

  key_capture #(.COLS(COLS), .ROWS(ROWS), .SYNC(SYNC)) u_keys (
    .clk             (clk),
    .rst             (rst),
    .row_sense       (row_sense),
    .sample          (sample),
    .col_idx         (col_idx),
    .key_state       (key_state),
    .key_change      (key_change),
    .key_change_col  (key_change_col),
    .key_change_rows (key_change_rows)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_drive <= '0;
      row_led   <= '0;
    end else if (boundary) begin
      col_drive <= COLS'(1) << next_col;
      row_led   <= rd_data;
    end
  end

  initial begin
    p_params_r7: assert (PRESCALE >= 4 && SAMPLE_AT >= SYNC && SAMPLE_AT < PRESCALE - 1);
    p_frame_rate_r3: assert (CLK_HZ / frame_clocks(COLS, PRESCALE) >= MIN_FRAME_HZ);
  end

  // R2: never two columns at once
  p_one_col_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(col_drive));

  // R2: once scanning, a column is always driven
  p_live_col_r2: assert property (@(posedge clk) disable iff (rst)
    live |-> $onehot(col_drive));

  // R2: columns advance by one position, wrapping at the top
  p_col_order_r2: assert property (@(posedge clk) disable iff (rst)
    (live && boundary) |=> col_drive == {$past(col_drive[COLS-2:0]), $past(col_drive[COLS-1])});

  // R4: drive and pattern stay put between boundaries
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> ($stable(col_drive) && $stable(row_led)));

endmodule

// File: tb/test_led_key_scanner.sv
module test_led_key_scanner;
  localparam int COLS      = 8;
  localparam int ROWS      = 8;
  localparam int PRESCALE  = 16;
  localparam int SAMPLE_AT = 13;
  localparam int SYNC      = 2;
  localparam int CW        = $clog2(COLS);
  localparam int FRAME     = COLS * PRESCALE;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 host_we = 1'b0;
  logic [CW-1:0]        host_addr = '0;
  logic [ROWS-1:0]      host_data = '0;
  logic [ROWS-1:0]      row_sense;
  logic [COLS-1:0]      col_drive;
  logic [ROWS-1:0]      row_led;
  logic [COLS*ROWS-1:0] key_state;
  logic                 key_change;
  logic [CW-1:0]        key_change_col;
  logic [ROWS-1:0]      key_change_rows;

  always #5 clk = ~clk;

  led_key_scanner #(.COLS(COLS), .ROWS(ROWS), .PRESCALE(PRESCALE),
                    .SAMPLE_AT(SAMPLE_AT), .SYNC(SYNC)) i_led_key_scanner (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_data(host_data), .row_sense(row_sense), .col_drive(col_drive),
    .row_led(row_led), .key_state(key_state), .key_change(key_change),
    .key_change_col(key_change_col), .key_change_rows(key_change_rows)
  );

  // switch matrix: a pressed switch connects its column to its row
  logic [ROWS-1:0] pressed [COLS];
  always_comb begin
    row_sense = '0;
    for (int c = 0; c < COLS; c++) if (col_drive[c]) row_sense |= pressed[c];
  end

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard state
  logic [CW+ROWS-1:0] exp_q [$];
  logic [ROWS-1:0]    kmodel [COLS];
  logic [ROWS-1:0]    model  [COLS];
  bit                 chk_pix = 1'b0;
  bit                 coll_on = 1'b0;
  int                 coll_col = 0;
  logic [ROWS-1:0]    coll_old = '0;

  // monitor
  logic [COLS-1:0] prev_drive = '0;
  logic [ROWS-1:0] prev_led   = '0;
  int              since      = 0;
  bit              seen       = 1'b0;

  always @(negedge clk) begin
    if (!rst && !done) begin
      since++;
      if (col_drive != prev_drive) begin
        int idx;
        logic [ROWS-1:0] want;
        if (seen) check(since == PRESCALE, "R3 column period", 64'(since), 64'(PRESCALE));
        check($onehot(col_drive), "R2 one column", 64'(col_drive), 64'(1));
        if (prev_drive != '0)
          check(col_drive == {prev_drive[COLS-2:0], prev_drive[COLS-1]}, "R2 column order",
                64'(col_drive), 64'({prev_drive[COLS-2:0], prev_drive[COLS-1]}));
        else
          check(col_drive == COLS'(1), "R2 first column", 64'(col_drive), 64'(1));
        idx = 0;
        for (int c = 0; c < COLS; c++) if (col_drive[c]) idx = c;
        if (chk_pix) begin
          want = model[idx];
          if (coll_on && idx == coll_col) begin
            want    = coll_old;
            coll_on = 1'b0;
          end
          check(row_led == want, "R4 row pattern", 64'(row_led), 64'(want));
        end
        seen  = 1'b1;
        since = 0;
      end else begin
        check(row_led == prev_led, "R4 pattern held", 64'(row_led), 64'(prev_led));
      end
      if (key_change) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected key event", 64'({key_change_col, key_change_rows}), 64'(0));
        end else begin
          logic [CW+ROWS-1:0] it;
          it = exp_q.pop_front();
          check({key_change_col, key_change_rows} == it, "R7 R8 key event",
                64'({key_change_col, key_change_rows}), 64'(it));
          check(key_state[int'(key_change_col)*ROWS +: ROWS] == key_change_rows, "R9 stored rows",
                64'(key_state[int'(key_change_col)*ROWS +: ROWS]), 64'(key_change_rows));
        end
      end
      prev_drive = col_drive;
      prev_led   = row_led;
    end
  end

  task automatic host_write(input int c, input logic [ROWS-1:0] d);
    while (col_drive != COLS'(1) << c) @(negedge clk);
    @(negedge clk);
    host_we   = 1'b1;
    host_addr = CW'(c);
    host_data = d;
    model[c]  = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  // write aimed at the fetch cycle of column c; optional second write next cycle
  task automatic clash_write(input int c, input logic [ROWS-1:0] d1, input bit twice, input logic [ROWS-1:0] d2);
    int p;
    p = (c + COLS - 1) % COLS;
    while (col_drive == COLS'(1) << p) @(negedge clk);
    while (col_drive != COLS'(1) << p) @(negedge clk);
    repeat (PRESCALE - 2) @(negedge clk);
    coll_old  = model[c];
    coll_col  = c;
    coll_on   = 1'b1;
    host_we   = 1'b1;
    host_addr = CW'(c);
    host_data = d1;
    model[c]  = d1;
    @(negedge clk);
    if (twice) begin
      host_data = d2;
      model[c]  = d2;
    end else begin
      host_we = 1'b0;
    end
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic set_keys(input int c, input logic [ROWS-1:0] rows);
    pressed[c] = rows;
    if (rows != kmodel[c]) exp_q.push_back({CW'(c), rows});
    kmodel[c] = rows;
    repeat (2 * FRAME) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < COLS; c++) begin
      pressed[c] = '0;
      kmodel[c]  = '0;
      model[c]   = '0;
    end
    repeat (4) @(negedge clk);
    // R1: reset state
    check(col_drive == '0, "R1 reset col_drive", 64'(col_drive), 64'(0));
    check(row_led == '0, "R1 reset row_led", 64'(row_led), 64'(0));
    check(key_state == '0, "R1 reset key_state", 64'(key_state), 64'(0));
    check(!key_change, "R1 reset key_change", 64'(key_change), 64'(0));
    rst = 1'b0;
    repeat (PRESCALE - 2) @(negedge clk);
    check(col_drive == '0, "R1 idle before first boundary", 64'(col_drive), 64'(0));
    // R3: frame rate at 10 ns per clock
    check(longint'(FRAME) * 10 < 20_000_000, "R3 frame under 20 ms", 64'(FRAME * 10), 64'(20_000_000));

    // R5: fill the pixel store
    for (int c = 0; c < COLS; c++) host_write(c, ROWS'(8'h11 * (c + 1)) ^ ROWS'(c << 1));
    repeat (FRAME + PRESCALE) @(negedge clk);
    chk_pix = 1'b1;
    repeat (2 * FRAME) @(negedge clk);
    host_write(4, 8'hA5);
    repeat (2 * FRAME) @(negedge clk);

    // R6: single clash, then a clash followed by a second write to the same column
    clash_write(2, 8'h3C, 1'b0, 8'h00);
    repeat (2 * FRAME) @(negedge clk);
    check(!coll_on, "R6 clash display seen", 64'(coll_on), 64'(0));
    clash_write(5, 8'hF0, 1'b1, 8'h0F);
    repeat (2 * FRAME) @(negedge clk);
    clash_write(0, 8'h81, 1'b0, 8'h00);
    repeat (2 * FRAME) @(negedge clk);

    // R7 R8: key patterns
    set_keys(0, 8'h01);
    set_keys(3, 8'h81);
    set_keys(7, 8'hFF);
    set_keys(3, 8'h81);
    set_keys(3, 8'h80);
    set_keys(0, 8'h00);
    set_keys(6, 8'h5A);

    // R9: whole key state against the model
    for (int c = 0; c < COLS; c++)
      check(key_state[c*ROWS +: ROWS] == kmodel[c], "R9 key state", 64'(key_state[c*ROWS +: ROWS]), 64'(kmodel[c]));
    check(exp_q.size() == 0, "R8 all events seen", 64'(exp_q.size()), 64'(0));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule